// File: doc/BRIEF.md
# IDE Register Decoder with Drive Shadowing

This block sits between a host I/O request port and two legacy IDE connectors, primary (channel 0) and secondary (channel 1). Each connector exposes an eight-byte command block and a four-byte control block. For every request the block decides whether the access is claimed and which chip select it raises: command block, control block, or a forward to the legacy expansion bus where the floppy controller answers. It also reports the register offset, the transfer width and the timing profile that the strobe generator should use.

Each connector can carry two drives, and each drive has its own timing profile, written through a small configuration port. The block snoops writes to the drive/head register (command offset 6) and keeps a per-connector copy of the drive-select bit. On a data-port access that copy picks the drive's profile. Fast timing is granted only on the data port. Every other register runs with compatible timing, counted in whole clock cycles.

All response outputs are registered. They are valid in the cycle after `req_valid` is sampled, and `rsp_valid` marks that cycle.

Top module: `ide_port_decoder`

## Requirements
- R1: After reset both shadow drive bits are 0 and every profile is compatible. A data-port access then gives `dev_drive`=0, `tim_fast`=0 and `tim_cycles`=COMPAT_CYC (default 9).
- R2: A command-block access (`req_ctrl`=0) to an enabled channel, at any offset 0..7, is claimed. It gives `cs_cmd`=1, `dev_off`=`req_off`, `dev_chan`=`req_chan`, and `rsp_valid`=1 one cycle after the request.
- R3: `dev_wide`=1 (16-bit transfer) only for command offset 0. Every other claimed access gives `dev_wide`=0.
- R4: A control-block access (`req_ctrl`=1) at offset 2 on an enabled channel is claimed with `cs_ctl`=1, `dev_off`=2 and `dev_wide`=0.
- R5: A control-block access at offset 3 is claimed with `legacy_fwd`=1. `cs_cmd` and `cs_ctl` both stay 0.
- R6: A control-block access at offset 0, 1 or 4..7 is not claimed and raises no select. A read there gives `rsp_ones`=1 (all-ones read data), and a write gives `rsp_ones`=0.
- R7: An access to a channel whose `chan_en` bit is 0 is not claimed and raises no select. A read gives `rsp_ones`=1. A write to its offset 6 leaves that channel's shadow drive bit unchanged.
- R8: A claimed write to command offset 6 captures bit 4 of `req_wdata` as that channel's drive bit. The other channel's bit is untouched. `dev_drive` shows the channel's bit as it stood before the access.
- R9: `tim_fast` can be 1 only on a command offset 0 access. Any other claimed access gives `tim_fast`=0 and `tim_cycles`=COMPAT_CYC. An unclaimed or forwarded access gives `tim_cycles`=0.
- R10: A `cfg_we` pulse writes `cfg_fast` and `cfg_cycles` into the profile chosen by `cfg_chan`/`cfg_drive`. A data-port access on that channel and drive then reports those values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | 2 | Per-channel range enable |
| cfg_we | input | 1 | Profile write strobe |
| cfg_chan | input | 1 | Profile channel select |
| cfg_drive | input | 1 | Profile drive select |
| cfg_fast | input | 1 | Fast-timing enable to store |
| cfg_cycles | input | 4 | Cycle count to store |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_chan | input | 1 | Target channel |
| req_ctrl | input | 1 | 1 = control block, 0 = command block |
| req_off | input | 3 | Register offset in block |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Response fields valid |
| rsp_claim | output | 1 | Access claimed |
| rsp_ones | output | 1 | Read data must be all ones |
| cs_cmd | output | 1 | Command-block chip select |
| cs_ctl | output | 1 | Control-block chip select |
| legacy_fwd | output | 1 | Forward to legacy expansion bus |
| dev_chan | output | 1 | Channel of the access |
| dev_off | output | 3 | Register offset to device |
| dev_wide | output | 1 | 16-bit transfer |
| dev_drive | output | 1 | Shadowed drive bit of the channel |
| tim_fast | output | 1 | Fast timing applies |
| tim_cycles | output | 4 | Cycle count for the access |

## Verification
The bench goes after the drive/head snoop. It flips the drive bit on one channel and checks that the other channel keeps its own. A design sharing one bit between channels would report the wrong drive and profile. It also checks that fast timing stays off on every register except data, even when the profile is fast. A decoder that applied the profile to all offsets would show fast timing on status reads. Reserved control offsets, the forwarded byte and a disabled channel are each probed. A wrong decoder there would raise a chip select, drop the all-ones read or update the shadow from an unclaimed write.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;
    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_CMD  = 2'd1,
        CLS_CTL  = 2'd2,
        CLS_FWD  = 2'd3
    } acc_cls_e;

    localparam logic [2:0] OFF_DATA    = 3'd0;
    localparam logic [2:0] OFF_DRVHEAD = 3'd6;
    localparam logic [2:0] OFF_ALTSTAT = 3'd2;
    localparam logic [2:0] OFF_LEGACY  = 3'd3;
endpackage

// File: rtl/ide_addr_decode.sv
module ide_addr_decode
    import ide_dec_pkg::*;
(
    input  logic       chan_on,
    input  logic       ctrl,
    input  logic [2:0] off,
    output acc_cls_e   cls,
    output logic       is_data
);
    always_comb begin
        cls     = CLS_NONE;
        is_data = 1'b0;
        if (chan_on) begin
            if (!ctrl) begin
                cls     = CLS_CMD;
                is_data = (off == OFF_DATA);
            end else if (off == OFF_ALTSTAT) begin
                cls = CLS_CTL;
            end else if (off == OFF_LEGACY) begin
                cls = CLS_FWD;
            end
        end
    end
endmodule

// File: rtl/ide_drive_shadow.sv
module ide_drive_shadow #(
    parameter int DATA_W  = 16,
    parameter int DRV_BIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic [DATA_W-1:0] wdata,
    output logic              drv_q
);
    logic drv_d;

    always_comb begin
        drv_d = drv_q;
        if (upd) drv_d = wdata[DRV_BIT];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) drv_q <= 1'b0;
        else        drv_q <= drv_d;
    end

    // R8
    shadow_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(upd)) |-> (drv_q == $past(wdata[DRV_BIT])));

    // R8
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(upd)) |-> $stable(drv_q));
endmodule

// File: rtl/ide_timing_bank.sv
module ide_timing_bank #(
    parameter int              CYC_W      = 4,
    parameter logic [CYC_W-1:0] COMPAT_CYC = 4'd9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_chan,
    input  logic             cfg_drive,
    input  logic             cfg_fast,
    input  logic [CYC_W-1:0] cfg_cycles,
    input  logic             rd_chan,
    input  logic             rd_drive,
    output logic             rd_fast,
    output logic [CYC_W-1:0] rd_cycles
);
    localparam int NPROF = 4;

    typedef struct packed {
        logic             fast;
        logic [CYC_W-1:0] cycles;
    } prof_t;

    prof_t prof_d [NPROF];
    prof_t prof_q [NPROF];

    logic [1:0] wr_idx;
    logic [1:0] rd_idx;
    assign wr_idx = {cfg_chan, cfg_drive};
    assign rd_idx = {rd_chan, rd_drive};

    always_comb begin
        for (int i = 0; i < NPROF; i++) prof_d[i] = prof_q[i];
        if (cfg_we) begin
            prof_d[wr_idx].fast   = cfg_fast;
            prof_d[wr_idx].cycles = cfg_cycles;
        end
    end

    generate
        for (genvar g = 0; g < NPROF; g++) begin : g_prof
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    prof_q[g].fast   <= 1'b0;
                    prof_q[g].cycles <= COMPAT_CYC;
                end else begin
                    prof_q[g] <= prof_d[g];
                end
            end
        end
    endgenerate

    assign rd_fast   = prof_q[rd_idx].fast;
    assign rd_cycles = prof_q[rd_idx].cycles;

    // R10
    cfg_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_we) && (rd_idx == $past(wr_idx)))
        |-> (rd_fast == $past(cfg_fast) && rd_cycles == $past(cfg_cycles)));
endmodule

// File: rtl/ide_port_decoder.sv
module ide_port_decoder
    import ide_dec_pkg::*;
#(
    parameter int               DATA_W     = 16,
    parameter int               DRV_BIT    = 4,
    parameter int               CYC_W      = 4,
    parameter logic [CYC_W-1:0] COMPAT_CYC = 4'd9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        chan_en,
    input  logic              cfg_we,
    input  logic              cfg_chan,
    input  logic              cfg_drive,
    input  logic              cfg_fast,
    input  logic [CYC_W-1:0]  cfg_cycles,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_chan,
    input  logic              req_ctrl,
    input  logic [2:0]        req_off,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_claim,
    output logic              rsp_ones,
    output logic              cs_cmd,
    output logic              cs_ctl,
    output logic              legacy_fwd,
    output logic              dev_chan,
    output logic [2:0]        dev_off,
    output logic              dev_wide,
    output logic              dev_drive,
    output logic              tim_fast,
    output logic [CYC_W-1:0]  tim_cycles
);
    localparam int NCHAN = 2;

    typedef struct packed {
        logic             valid;
        logic             claim;
        logic             ones;
        logic             cs_cmd;
        logic             cs_ctl;
        logic             fwd;
        logic             chan;
        logic [2:0]       off;
        logic             wide;
        logic             drive;
        logic             fast;
        logic [CYC_W-1:0] cycles;
    } rsp_t;

    rsp_t r_d, r_q;

    acc_cls_e   cls;
    logic       is_data;
    logic [NCHAN-1:0] drv_q;
    logic       sel_drive;
    logic       prof_fast;
    logic [CYC_W-1:0] prof_cycles;

    ide_addr_decode u_dec (
        .chan_on (chan_en[req_chan]),
        .ctrl    (req_ctrl),
        .off     (req_off),
        .cls     (cls),
        .is_data (is_data)
    );

    generate
        for (genvar c = 0; c < NCHAN; c++) begin : g_chan
            logic upd;
            assign upd = req_valid && req_write && chan_en[c] && (req_chan == c[0])
                         && !req_ctrl && (req_off == OFF_DRVHEAD);
            ide_drive_shadow #(.DATA_W(DATA_W), .DRV_BIT(DRV_BIT)) u_shadow (
                .clk   (clk),
                .rst_n (rst_n),
                .upd   (upd),
                .wdata (req_wdata),
                .drv_q (drv_q[c])
            );
        end
    endgenerate

    assign sel_drive = drv_q[req_chan];

    ide_timing_bank #(.CYC_W(CYC_W), .COMPAT_CYC(COMPAT_CYC)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_chan   (cfg_chan),
        .cfg_drive  (cfg_drive),
        .cfg_fast   (cfg_fast),
        .cfg_cycles (cfg_cycles),
        .rd_chan    (req_chan),
        .rd_drive   (sel_drive),
        .rd_fast    (prof_fast),
        .rd_cycles  (prof_cycles)
    );

    always_comb begin
        r_d        = '0;
        r_d.valid  = req_valid;
        if (req_valid) begin
            r_d.chan   = req_chan;
            r_d.off    = req_off;
            r_d.drive  = sel_drive;
            r_d.claim  = (cls != CLS_NONE);
            r_d.ones   = (cls == CLS_NONE) && !req_write;
            r_d.cs_cmd = (cls == CLS_CMD);
            r_d.cs_ctl = (cls == CLS_CTL);
            r_d.fwd    = (cls == CLS_FWD);
            r_d.wide   = is_data;
            if (is_data) begin
                r_d.fast   = prof_fast;
                r_d.cycles = prof_cycles;
            end else if (cls == CLS_CMD || cls == CLS_CTL) begin
                r_d.cycles = COMPAT_CYC;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rsp_valid  = r_q.valid;
    assign rsp_claim  = r_q.claim;
    assign rsp_ones   = r_q.ones;
    assign cs_cmd     = r_q.cs_cmd;
    assign cs_ctl     = r_q.cs_ctl;
    assign legacy_fwd = r_q.fwd;
    assign dev_chan   = r_q.chan;
    assign dev_off    = r_q.off;
    assign dev_wide   = r_q.wide;
    assign dev_drive  = r_q.drive;
    assign tim_fast   = r_q.fast;
    assign tim_cycles = r_q.cycles;

    // R5
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cs_cmd, cs_ctl, legacy_fwd}));

    // R6
    no_sel_unclaimed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_claim |-> (!cs_cmd && !cs_ctl && !legacy_fwd && !tim_fast));

    // R9
    fast_data_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tim_fast |-> (cs_cmd && dev_wide && dev_off == OFF_DATA));

    // R3
    wide_cmd_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_wide |-> (cs_cmd && dev_off == OFF_DATA));

    // R2
    rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(req_valid)) |-> rsp_valid);
endmodule

// File: tb/ide_port_decoder_tb_top.sv
module ide_port_decoder_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [1:0]  chan_en = 2'b11;
    logic        cfg_we = 0, cfg_chan = 0, cfg_drive = 0, cfg_fast = 0;
    logic [3:0]  cfg_cycles = 0;
    logic        req_valid = 0, req_write = 0, req_chan = 0, req_ctrl = 0;
    logic [2:0]  req_off = 0;
    logic [15:0] req_wdata = 0;
    logic        rsp_valid, rsp_claim, rsp_ones, cs_cmd, cs_ctl, legacy_fwd;
    logic        dev_chan, dev_wide, dev_drive, tim_fast;
    logic [2:0]  dev_off;
    logic [3:0]  tim_cycles;

    int checks = 0;
    int fails  = 0;
    localparam logic [3:0] COMPAT = 4'd9;

    ide_port_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en),
        .cfg_we(cfg_we), .cfg_chan(cfg_chan), .cfg_drive(cfg_drive),
        .cfg_fast(cfg_fast), .cfg_cycles(cfg_cycles),
        .req_valid(req_valid), .req_write(req_write), .req_chan(req_chan),
        .req_ctrl(req_ctrl), .req_off(req_off), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_claim(rsp_claim), .rsp_ones(rsp_ones),
        .cs_cmd(cs_cmd), .cs_ctl(cs_ctl), .legacy_fwd(legacy_fwd),
        .dev_chan(dev_chan), .dev_off(dev_off), .dev_wide(dev_wide),
        .dev_drive(dev_drive), .tim_fast(tim_fast), .tim_cycles(tim_cycles)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // drive at negedge, response registered at next posedge, sample at next negedge
    task automatic access(input bit wr, input bit ch, input bit ctl,
                          input logic [2:0] off, input logic [15:0] wd);
        req_valid = 1; req_write = wr; req_chan = ch; req_ctrl = ctl;
        req_off = off; req_wdata = wd;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic cfg(input bit ch, input bit drv, input bit fast, input logic [3:0] cyc);
        cfg_we = 1; cfg_chan = ch; cfg_drive = drv; cfg_fast = fast; cfg_cycles = cyc;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic t_reset;
        chk(!rsp_valid && !rsp_claim && !cs_cmd, "R1 idle after reset", rsp_valid, 0);
        access(0, 0, 0, 3'd0, 0);
        chk(dev_drive == 0, "R1 drive0 ch0", dev_drive, 0);
        chk(tim_fast == 0 && tim_cycles == COMPAT, "R1 compat cycles", tim_cycles, COMPAT);
        access(0, 1, 0, 3'd0, 0);
        chk(dev_drive == 0 && tim_fast == 0, "R1 drive0 ch1", dev_drive, 0);
    endtask

    task automatic t_cmd_sweep;
        for (int o = 0; o < 8; o++) begin
            access(o[0], o[1], 0, o[2:0], 16'h0000);
            chk(rsp_valid && rsp_claim && cs_cmd && !cs_ctl && !legacy_fwd,
                "R2 cmd claim", cs_cmd, 1);
            chk(dev_off == o[2:0] && dev_chan == o[1], "R2 cmd offset", dev_off, o);
            chk(dev_wide == (o == 0), "R3 width", dev_wide, (o == 0));
        end
    endtask

    task automatic t_ctl;
        access(0, 1, 1, 3'd2, 0);
        chk(cs_ctl && !cs_cmd && rsp_claim && dev_off == 2, "R4 altstat read", cs_ctl, 1);
        chk(!dev_wide && tim_cycles == COMPAT && !tim_fast, "R4 narrow compat", dev_wide, 0);
        access(1, 0, 1, 3'd3, 16'h00ff);
        chk(legacy_fwd && rsp_claim && !cs_ctl && !cs_cmd, "R5 forward", legacy_fwd, 1);
        chk(tim_cycles == 0, "R9 fwd no timing", tim_cycles, 0);
        for (int o = 0; o < 8; o++) begin
            if (o == 2 || o == 3) continue;
            access(0, 0, 1, o[2:0], 0);
            chk(!rsp_claim && !cs_ctl && !cs_cmd && !legacy_fwd && rsp_ones,
                "R6 reserved read", rsp_claim, 0);
        end
        access(1, 1, 1, 3'd1, 16'hffff);
        chk(!rsp_claim && !rsp_ones && rsp_valid, "R6 reserved write", rsp_ones, 0);
    endtask

    task automatic t_shadow;
        cfg(0, 1, 1, 4'd3);
        cfg(0, 0, 0, 4'd7);
        access(1, 0, 0, 3'd6, 16'h0010);
        chk(dev_drive == 0, "R8 drive shown before update", dev_drive, 0);
        access(0, 0, 0, 3'd0, 0);
        chk(dev_drive == 1, "R8 ch0 drive1", dev_drive, 1);
        chk(tim_fast == 1 && tim_cycles == 3, "R10 ch0 drive1 profile", tim_cycles, 3);
        access(0, 1, 0, 3'd0, 0);
        chk(dev_drive == 0 && tim_fast == 0 && tim_cycles == COMPAT, "R8 ch1 untouched",
            dev_drive, 0);
        access(0, 0, 0, 3'd7, 0);
        chk(tim_fast == 0 && tim_cycles == COMPAT, "R9 status compat", tim_fast, 0);
        access(1, 0, 0, 3'd6, 16'h0010);
        chk(tim_fast == 0 && tim_cycles == COMPAT, "R9 drvhead compat", tim_fast, 0);
        access(1, 0, 0, 3'd6, 16'h00ef);
        access(0, 0, 0, 3'd0, 0);
        chk(dev_drive == 0 && tim_cycles == 7 && !tim_fast, "R10 ch0 drive0 profile",
            tim_cycles, 7);
    endtask

    task automatic t_disabled;
        chan_en = 2'b01;
        access(1, 1, 0, 3'd6, 16'h0010);
        chk(!rsp_claim && !cs_cmd && !rsp_ones, "R7 disabled write", rsp_claim, 0);
        access(0, 1, 0, 3'd0, 0);
        chk(!rsp_claim && !cs_cmd && rsp_ones && !tim_fast && tim_cycles == 0,
            "R7 disabled read", rsp_ones, 1);
        chan_en = 2'b11;
        access(0, 1, 0, 3'd0, 0);
        chk(dev_drive == 0 && rsp_claim, "R7 shadow unchanged", dev_drive, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_cmd_sweep();
        t_ctl();
        t_shadow();
        t_disabled();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule